// File: doc/BRIEF.md
# Overlapped Register Window File

This block is a procedure-oriented register file. Software sees 32 logical registers, but most of them live in a larger physical array that is cut into windows. A window pointer picks the active window. A call strobe moves to a fresh window, and a return strobe moves back. The six registers a caller fills with outgoing arguments are the same storage the callee reads as its incoming arguments, so no copy is ever made. Ten low-numbered registers sit outside the windows and are shared by every procedure. Logical register 0 is hard-wired to zero.

The physical array has 10 shared entries and 8 windows of 16 entries each, arranged as a ring. The block keeps a count of the windows that hold live data. A call that finds no free window does not move the pointer. Instead it raises a one-cycle overflow trap. A return whose caller window is not resident raises an underflow trap in the same way. An external handler moves windows to and from memory. It reports each window it saves or restores through acknowledgement strobes, and these strobes adjust the resident count.

There are two combinational read ports and one write port, which writes on the rising clock edge. All three take 5-bit logical addresses.

Top module: `rwin_file`

## Requirements
- R1: Logical register 0 reads as zero on both read ports, and a write addressed to it changes nothing.
- R2: Logical registers 1 to 9 are shared: a value written in one window reads back unchanged in every other window.
- R3: Registers 10-15 are the outgoing group, 16-25 the private group and 26-31 the incoming group. After a call, the callee's registers 26+k (k = 0..5) read the caller's registers 10+k, and the callee's private group is storage separate from the caller's.
- R4: A return makes the caller's registers visible again. The caller's private group is unchanged by the callee, and the callee's writes to registers 26+k read back in the caller as registers 10+k.
- R5: `win_ptr` shows the current window. An accepted call decrements it modulo 8, and an accepted return increments it modulo 8. Both changes appear one clock edge after the strobe.
- R6: After reset, `win_ptr` is 0, exactly one window is resident, and both trap outputs are low.
- R7: A call made while 7 windows are resident raises `ovf_trap` for exactly the one cycle after the strobe and leaves `win_ptr` and the resident count unchanged.
- R8: A return made while 1 window is resident raises `unf_trap` for exactly the one cycle after the strobe and leaves `win_ptr` unchanged.
- R9: A spill acknowledgement lowers the resident count by one, but not below 1. A fill acknowledgement raises it by one, but not above 7. An acknowledgement that coincides with a call or return strobe, or with the opposite acknowledgement, is dropped.
- R10: A read of a register that is being written in the same cycle returns the old value. The new value is readable after that edge.
- R11: A write in the same cycle as a call or return lands in the window that was current before that edge.
- R12: Call and return strobes asserted together have no effect: the pointer holds and no trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Logical address, read port A |
| rd_data_a | output | DATA_W | Read data, port A (combinational) |
| rd_addr_b | input | 5 | Logical address, read port B |
| rd_data_b | output | DATA_W | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical write address |
| wr_data | input | DATA_W | Write data |
| call_req | input | 1 | Procedure call strobe |
| ret_req | input | 1 | Procedure return strobe |
| spill_ack | input | 1 | Handler has saved one window to memory |
| fill_ack | input | 1 | Handler has restored one window from memory |
| ovf_trap | output | 1 | Registered pulse: call found no free window |
| unf_trap | output | 1 | Registered pulse: return found caller not resident |
| win_ptr | output | log2(NUM_WIN) | Current window pointer |

## Verification
Two functions can coincide on one edge. A register write can share a cycle with a call, which moves the window pointer. A handler acknowledgement can share a cycle with a call strobe that overflows. For the first case, the bench drives a write and a call on the same cycle. It then overwrites the same logical register inside the callee and returns. The caller must still hold the value from the coincident write, which shows the write used the old pointer. For the second case, a spill and a call are raised together with seven windows resident. The call must trap, and a later call must trap as well, which shows the spill was dropped. Read-during-write and simultaneous call and return strobes are judged the same way, by their visible effect at the ports.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

  localparam int unsigned LADDR_W    = 5;
  localparam int unsigned GLOBAL_CNT = 10;
  localparam int unsigned OUT_CNT    = 6;
  localparam int unsigned PRIV_CNT   = 10;
  localparam int unsigned WIN_STRIDE = OUT_CNT + PRIV_CNT;
  localparam int unsigned MAP_PORTS  = 3;

  typedef enum logic [1:0] {
    WIN_IDLE = 2'd0,
    WIN_CALL = 2'd1,
    WIN_RET  = 2'd2,
    WIN_HOLD = 2'd3
  } win_op_e;

  function automatic win_op_e decode_op(input logic call_s, input logic ret_s);
    unique case ({call_s, ret_s})
      2'b10:   return WIN_CALL;
      2'b01:   return WIN_RET;
      2'b11:   return WIN_HOLD;
      default: return WIN_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/rwin_map.sv
module rwin_map
  import rwin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned CWP_W   = 3,
  parameter int unsigned PHYS_W  = 8
) (
  input  logic [CWP_W-1:0]   cwp,
  input  logic [LADDR_W-1:0] laddr,
  output logic [PHYS_W-1:0]  paddr
);

  localparam int unsigned WREG_CNT = NUM_WIN * WIN_STRIDE;
  localparam int unsigned SUM_W    = PHYS_W + 1;

  logic [SUM_W-1:0] ring_off;

  always_comb begin
    ring_off = '0;
    if (laddr < LADDR_W'(GLOBAL_CNT)) begin
      paddr = PHYS_W'(laddr);
    end else begin
      ring_off = SUM_W'(cwp) * SUM_W'(WIN_STRIDE)
               + SUM_W'(laddr) - SUM_W'(GLOBAL_CNT);
      if (ring_off >= SUM_W'(WREG_CNT)) begin
        ring_off = ring_off - SUM_W'(WREG_CNT);
      end
      paddr = PHYS_W'(ring_off + SUM_W'(GLOBAL_CNT));
    end
  end

endmodule

// File: rtl/rwin_store.sv
module rwin_store #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned PHYS_CNT = 138,
  parameter int unsigned PHYS_W   = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [PHYS_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  logic [DATA_W-1:0] mem [PHYS_CNT];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/rwin_ptr.sv
module rwin_ptr
  import rwin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned CWP_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             call_req,
  input  logic             ret_req,
  input  logic             spill_ack,
  input  logic             fill_ack,
  output logic [CWP_W-1:0] cwp,
  output logic             ovf_trap,
  output logic             unf_trap
);

  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NUM_WIN - 1);
  localparam logic [CWP_W-1:0] MAX_RES  = CWP_W'(NUM_WIN - 1);
  localparam logic [CWP_W-1:0] MIN_RES  = CWP_W'(1);

  logic [CWP_W-1:0] res_cnt;
  win_op_e          op;
  logic             full;
  logic             lone;

  assign op   = decode_op(call_req, ret_req);
  assign full = (res_cnt == MAX_RES);
  assign lone = (res_cnt == MIN_RES);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp      <= '0;
      res_cnt  <= MIN_RES;
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
      unique case (op)
        WIN_CALL: begin
          if (full) begin
            ovf_trap <= 1'b1;
          end else begin
            cwp     <= (cwp == '0) ? LAST_WIN : cwp - 1'b1;
            res_cnt <= res_cnt + 1'b1;
          end
        end
        WIN_RET: begin
          if (lone) begin
            unf_trap <= 1'b1;
          end else begin
            cwp     <= (cwp == LAST_WIN) ? '0 : cwp + 1'b1;
            res_cnt <= res_cnt - 1'b1;
          end
        end
        WIN_IDLE: begin
          if (spill_ack && !fill_ack && !lone) begin
            res_cnt <= res_cnt - 1'b1;
          end else if (fill_ack && !spill_ack && !full) begin
            res_cnt <= res_cnt + 1'b1;
          end
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/rwin_file.sv
module rwin_file
  import rwin_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 8,
  localparam int unsigned CWP_W  = $clog2(NUM_WIN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LADDR_W-1:0]  rd_addr_a,
  output logic [DATA_W-1:0]   rd_data_a,
  input  logic [LADDR_W-1:0]  rd_addr_b,
  output logic [DATA_W-1:0]   rd_data_b,
  input  logic                wr_en,
  input  logic [LADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                call_req,
  input  logic                ret_req,
  input  logic                spill_ack,
  input  logic                fill_ack,
  output logic                ovf_trap,
  output logic                unf_trap,
  output logic [CWP_W-1:0]    win_ptr
);

  localparam int unsigned PHYS_CNT = GLOBAL_CNT + NUM_WIN * WIN_STRIDE;
  localparam int unsigned PHYS_W   = $clog2(PHYS_CNT);

  logic [CWP_W-1:0]   cwp;
  logic [LADDR_W-1:0] laddr [MAP_PORTS];
  logic [PHYS_W-1:0]  paddr [MAP_PORTS];
  logic [DATA_W-1:0]  raw_a;
  logic [DATA_W-1:0]  raw_b;
  logic               we_eff;

  rwin_ptr #(
    .NUM_WIN (NUM_WIN),
    .CWP_W   (CWP_W)
  ) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .call_req  (call_req),
    .ret_req   (ret_req),
    .spill_ack (spill_ack),
    .fill_ack  (fill_ack),
    .cwp       (cwp),
    .ovf_trap  (ovf_trap),
    .unf_trap  (unf_trap)
  );

  assign laddr[0] = rd_addr_a;
  assign laddr[1] = rd_addr_b;
  assign laddr[2] = wr_addr;

  generate
    for (genvar p = 0; p < MAP_PORTS; p++) begin : g_map
      rwin_map #(
        .NUM_WIN (NUM_WIN),
        .CWP_W   (CWP_W),
        .PHYS_W  (PHYS_W)
      ) u_map (
        .cwp   (cwp),
        .laddr (laddr[p]),
        .paddr (paddr[p])
      );
    end
  endgenerate

  assign we_eff = wr_en && (wr_addr != '0);

  rwin_store #(
    .DATA_W   (DATA_W),
    .PHYS_CNT (PHYS_CNT),
    .PHYS_W   (PHYS_W)
  ) u_store (
    .clk     (clk),
    .we      (we_eff),
    .waddr   (paddr[2]),
    .wdata   (wr_data),
    .raddr_a (paddr[0]),
    .rdata_a (raw_a),
    .raddr_b (paddr[1]),
    .rdata_b (raw_b)
  );

  assign rd_data_a = (rd_addr_a == '0) ? '0 : raw_a;
  assign rd_data_b = (rd_addr_b == '0) ? '0 : raw_b;
  assign win_ptr   = cwp;

endmodule

// File: rtl/rwin_file_chk.sv
module rwin_file_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_WIN = 8,
  parameter int unsigned CWP_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        rd_addr_a,
  input logic [DATA_W-1:0] rd_data_a,
  input logic              call_req,
  input logic              ret_req,
  input logic              ovf_trap,
  input logic              unf_trap,
  input logic [CWP_W-1:0]  win_ptr
);

  localparam logic [CWP_W-1:0] LAST_WIN = CWP_W'(NUM_WIN - 1);

  // R1
  a_r1_zero_read: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == 5'd0) |-> (rd_data_a == '0));

  // R5
  a_r5_call_steps_down: assert property (@(posedge clk) disable iff (rst)
    (call_req && !ret_req) |=> (ovf_trap ||
      (win_ptr == (($past(win_ptr) == '0) ? LAST_WIN : $past(win_ptr) - 1'b1))));

  // R7
  a_r7_ovf_holds_ptr: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> ($stable(win_ptr) && $past(call_req) && !$past(ret_req)));

  // R8
  a_r8_unf_holds_ptr: assert property (@(posedge clk) disable iff (rst)
    unf_trap |-> ($stable(win_ptr) && $past(ret_req) && !$past(call_req)));

  // R7 and R8
  a_r8_traps_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({ovf_trap, unf_trap}) <= 1);

  // R12
  a_r12_both_strobes_idle: assert property (@(posedge clk) disable iff (rst)
    (call_req && ret_req) |=> ($stable(win_ptr) && !ovf_trap && !unf_trap));

endmodule

bind rwin_file rwin_file_chk #(
  .DATA_W  (DATA_W),
  .NUM_WIN (NUM_WIN),
  .CWP_W   (CWP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_addr_a (rd_addr_a),
  .rd_data_a (rd_data_a),
  .call_req  (call_req),
  .ret_req   (ret_req),
  .ovf_trap  (ovf_trap),
  .unf_trap  (unf_trap),
  .win_ptr   (win_ptr)
);

// File: tb/rwin_file_bench.sv
`timescale 1ns/1ps
module rwin_file_bench;

  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic [4:0]    rd_addr_a, rd_addr_b, wr_addr;
  logic [DW-1:0] rd_data_a, rd_data_b, wr_data;
  logic          wr_en, call_req, ret_req, spill_ack, fill_ack;
  logic          ovf_trap, unf_trap;
  logic [2:0]    win_ptr;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_ptr;
  int exp_res;

  always #2.5 clk = ~clk;

  rwin_file u_rwin_file (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .call_req(call_req), .ret_req(ret_req),
    .spill_ack(spill_ack), .fill_ack(fill_ack),
    .ovf_trap(ovf_trap), .unf_trap(unf_trap), .win_ptr(win_ptr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_a(input logic [4:0] a, output logic [31:0] d);
    rd_addr_a = a; #1; d = rd_data_a;
  endtask

  task automatic rd_b(input logic [4:0] a, output logic [31:0] d);
    rd_addr_b = a; #1; d = rd_data_b;
  endtask

  task automatic do_call(input string req);
    logic exp_ovf;
    @(negedge clk); call_req = 1'b1;
    @(negedge clk); call_req = 1'b0;
    exp_ovf = (exp_res == 7);
    if (!exp_ovf) begin exp_ptr = (exp_ptr + 7) % 8; exp_res++; end
    check({req, " call ptr"}, 32'(win_ptr), 32'(exp_ptr));
    check({req, " call ovf"}, 32'(ovf_trap), 32'(exp_ovf));
  endtask

  task automatic do_ret(input string req);
    logic exp_unf;
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    exp_unf = (exp_res == 1);
    if (!exp_unf) begin exp_ptr = (exp_ptr + 1) % 8; exp_res--; end
    check({req, " ret ptr"}, 32'(win_ptr), 32'(exp_ptr));
    check({req, " ret unf"}, 32'(unf_trap), 32'(exp_unf));
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R6 ptr", 32'(win_ptr), 32'd0);
    check("R6 ovf", 32'(ovf_trap), 32'd0);
    check("R6 unf", 32'(unf_trap), 32'd0);
    rd_a(5'd0, d); check("R1 r0 after reset", d, 32'd0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(5'd0, 32'hDEAD_BEEF);
    rd_a(5'd0, d); check("R1 r0 port A", d, 32'd0);
    rd_b(5'd0, d); check("R1 r0 port B", d, 32'd0);
  endtask

  task automatic t_global;
    logic [31:0] d;
    wr(5'd5, 32'h0000_0055);
    do_call("R5");
    rd_a(5'd5, d); check("R2 r5 in callee", d, 32'h55);
    wr(5'd9, 32'h0000_0099);
    do_ret("R5");
    rd_b(5'd9, d); check("R2 r9 in caller", d, 32'h99);
  endtask

  task automatic t_overlap;
    logic [31:0] d;
    for (int k = 0; k < 6; k++) wr(5'(10 + k), 32'h100 + 32'(k));
    wr(5'd16, 32'h0000_AAAA);
    do_call("R3");
    for (int k = 0; k < 6; k++) begin
      rd_b(5'(26 + k), d); check("R3 incoming equals caller outgoing", d, 32'h100 + 32'(k));
    end
    wr(5'd16, 32'h0000_BBBB);
    wr(5'd31, 32'h0000_0777);
    rd_a(5'd16, d); check("R3 callee private", d, 32'hBBBB);
    do_ret("R4");
    rd_a(5'd16, d); check("R4 caller private kept", d, 32'hAAAA);
    rd_a(5'd15, d); check("R4 result seen in r15", d, 32'h777);
  endtask

  task automatic t_rdw;
    logic [31:0] d;
    wr(5'd20, 32'h0000_0011);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd20; wr_data = 32'h0000_0022;
    rd_a(5'd20, d); check("R10 old value same cycle", d, 32'h11);
    @(negedge clk);
    wr_en = 1'b0;
    #1; check("R10 new value next cycle", rd_data_a, 32'h22);
  endtask

  task automatic t_wr_call;
    logic [31:0] d;
    wr(5'd17, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'h0000_C0DE; call_req = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; call_req = 1'b0;
    exp_ptr = (exp_ptr + 7) % 8; exp_res++;
    check("R11 ptr after call", 32'(win_ptr), 32'(exp_ptr));
    wr(5'd17, 32'h0000_3333);
    do_ret("R11");
    rd_a(5'd17, d); check("R11 write used old window", d, 32'hC0DE);
  endtask

  task automatic t_both;
    @(negedge clk); call_req = 1'b1; ret_req = 1'b1;
    @(negedge clk); call_req = 1'b0; ret_req = 1'b0;
    check("R12 ptr held", 32'(win_ptr), 32'(exp_ptr));
    check("R12 no traps", 32'({ovf_trap, unf_trap}), 32'd0);
  endtask

  task automatic t_underflow;
    do_ret("R8 underflow");
    @(negedge clk); fill_ack = 1'b1;
    @(negedge clk); fill_ack = 1'b0;
    exp_res++;
    do_ret("R9 after fill");
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 6; k++) do_call("R5 fill ring");
    do_call("R7 overflow");
    @(negedge clk);
    check("R7 trap is one pulse", 32'(ovf_trap), 32'd0);
    check("R7 ptr held", 32'(win_ptr), 32'(exp_ptr));
  endtask

  task automatic t_ack;
    @(negedge clk); call_req = 1'b1; spill_ack = 1'b1;
    @(negedge clk); call_req = 1'b0; spill_ack = 1'b0;
    check("R9 call with spill traps", 32'(ovf_trap), 32'd1);
    do_call("R9 coincident spill dropped");
    @(negedge clk); spill_ack = 1'b1;
    @(negedge clk); spill_ack = 1'b0;
    exp_res--;
    do_call("R9 spill frees window");
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    call_req = 1'b0; ret_req = 1'b0; spill_ack = 1'b0; fill_ack = 1'b0;
    exp_ptr = 0; exp_res = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_zero;
    t_global;
    t_overlap;
    t_rdw;
    t_wr_call;
    t_both;
    t_underflow;
    t_overflow;
    t_ack;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule